// File: doc/BRIEF.md
# Zero-Run Auto Mute and Soft Mute Controller

This block sits beside an audio datapath and decides how loud the output may be. It watches each decoded stereo sample pair, marked by a valid strobe, and produces a gain word. The datapath multiplies both channels by this gain. It also produces a flag that is high when the output is fully silent.

Muting is set by a mute control pin that has three states. When the pin is held low, muting is off and zero detection is disabled. When it is held high, a soft mute is forced. When it is left floating, the block counts successive sample pairs in which both channels are zero and enters auto mute once the run is long enough. Gain never jumps. On each valid sample it moves one fixed step toward silence or toward unity, so a mute or release fades in a few samples rather than clicking.

The internal auto-mute state is driven back onto the shared pin as a weak source. The block models this as a resolved pin level: an external driver wins, and a floating pin shows the auto-mute state. The analogue driver and resistor are not part of the block. The pin state arrives already resolved as a two-bit code.

Top module: `zmute_ctrl`

## Requirements
- R1: After reset the gain output is at unity (all ones, GAIN_MAX), auto mute is inactive and the full-mute flag is low.
- R2: With the pin floating, auto mute asserts on the clock edge that accepts the RUN_LEN-th (default 64) successive valid pair in which both left and right are zero, and not one pair earlier.
- R3: A valid pair with a non-zero left or right word clears the zero run and drops auto mute at that same edge.
- R4: The zero-run count saturates at RUN_LEN: further zero pairs keep auto mute asserted and never wrap it off.
- R5: Pin code 2'b00 (driven low) disables auto mute. The run is cleared on every clock, auto mute stays low however many zero pairs arrive, and the gain returns toward unity.
- R6: Pin code 2'b01 (driven high) forces soft mute, so each valid sample lowers the gain.
- R7: The gain changes only on clocks with a valid sample. Each change is exactly GAIN_STEP (default 32) toward the target, saturating at 0 going down and at GAIN_MAX going up.
- R8: The pin level output is 0 for code 2'b00 and 1 for code 2'b01. For a floating pin it equals the auto-mute state.
- R9: The full-mute output is high exactly when the gain is 0.
- R10: Pin codes 2'b10 and 2'b11 are both treated as floating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A stereo sample pair is present this cycle |
| smp_left | input | SMP_W | Left channel sample word |
| smp_right | input | SMP_W | Right channel sample word |
| mute_pin | input | 2 | Resolved pin state: 00 low, 01 high, 10/11 floating |
| gain_out | output | GAIN_W | Gain word applied to both channels |
| mute_full | output | 1 | Gain has reached zero |
| auto_mute | output | 1 | Auto-mute state from the zero-run detector |
| pin_level | output | 1 | Level seen on the shared pin (weak status when floating) |

## Verification
The hardest state to reach is the edge of the zero run. Auto mute must hold off through 63 zero pairs, assert on the 64th, and stay asserted far past that point. Random samples almost never produce such a run. The stimulus therefore draws zero pairs with high probability, and directed sequences feed exactly 63, 64 and well over 64 zero pairs. A non-zero word is then placed on only one channel at a time. Pin changes made in the middle of a run, and clocks without a valid strobe while the gain is ramping, test that ramp steps are gated by the strobe.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  typedef enum logic [1:0] {
    PIN_LOW   = 2'b00,
    PIN_HIGH  = 2'b01,
    PIN_FLOAT = 2'b10
  } pin_mode_e;

  // Both floating codes collapse into one mode.
  function automatic pin_mode_e decode_pin(input logic [1:0] code);
    case (code)
      2'b00:   return PIN_LOW;
      2'b01:   return PIN_HIGH;
      default: return PIN_FLOAT;
    endcase
  endfunction
endpackage

// File: rtl/zmute_pin_resolve.sv
module zmute_pin_resolve
  import zmute_pkg::*;
(
  input  logic [1:0] mute_pin,
  input  logic       auto_flag,
  output logic       is_float,
  output logic       is_high,
  output logic       pin_level
);
  pin_mode_e mode;

  always_comb begin
    mode     = decode_pin(mute_pin);
    is_float = (mode == PIN_FLOAT);
    is_high  = (mode == PIN_HIGH);
    // A weak source loses to any external driver.
    pin_level = is_float ? auto_flag : is_high;
  end
endmodule

// File: rtl/zmute_zero_run.sv
module zmute_zero_run #(
  parameter int SMP_W   = 24,
  parameter int RUN_LEN = 64,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic [CNT_W-1:0] run_cnt,
  output logic             auto_flag,
  output logic             pair_zero
);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(RUN_LEN);

  function automatic logic [CNT_W-1:0] run_next(input logic [CNT_W-1:0] cur,
                                                input logic            zero);
    if (!zero)          return '0;
    if (cur == RUN_TOP) return cur;
    return cur + 1'b1;
  endfunction

  assign pair_zero = (smp_left == '0) && (smp_right == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (!enable)   run_cnt <= '0;
    else if (smp_valid) run_cnt <= run_next(run_cnt, pair_zero);
  end

  assign auto_flag = (run_cnt == RUN_TOP);
endmodule

// File: rtl/zmute_gain_ramp.sv
module zmute_gain_ramp #(
  parameter int GAIN_W    = 8,
  parameter int GAIN_STEP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              mute_req,
  output logic [GAIN_W-1:0] gain,
  output logic              muted
);
  localparam logic [GAIN_W-1:0] G_MAX  = {GAIN_W{1'b1}};
  localparam logic [GAIN_W-1:0] G_STEP = GAIN_W'(GAIN_STEP);

  function automatic logic [GAIN_W-1:0] ramp_next(input logic [GAIN_W-1:0] g,
                                                  input logic              down);
    if (down) return (g > G_STEP) ? g - G_STEP : '0;
    return ((G_MAX - g) > G_STEP) ? g + G_STEP : G_MAX;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain <= G_MAX;
    else if (smp_valid) gain <= ramp_next(gain, mute_req);
  end

  assign muted = (gain == '0);
endmodule

// File: rtl/zmute_ctrl.sv
module zmute_ctrl #(
  parameter int SMP_W     = 24,
  parameter int GAIN_W    = 8,
  parameter int GAIN_STEP = 32,
  parameter int RUN_LEN   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_left,
  input  logic [SMP_W-1:0]  smp_right,
  input  logic [1:0]        mute_pin,
  output logic [GAIN_W-1:0] gain_out,
  output logic              mute_full,
  output logic              auto_mute,
  output logic              pin_level
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic             is_float;
  logic             is_high;
  logic             auto_flag;
  logic             pair_zero;
  logic             mute_req;
  logic [CNT_W-1:0] run_cnt;

  zmute_pin_resolve u_pin (
    .mute_pin (mute_pin),
    .auto_flag(auto_flag),
    .is_float (is_float),
    .is_high  (is_high),
    .pin_level(pin_level)
  );

  zmute_zero_run #(.SMP_W(SMP_W), .RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (is_float),
    .smp_valid(smp_valid),
    .smp_left (smp_left),
    .smp_right(smp_right),
    .run_cnt  (run_cnt),
    .auto_flag(auto_flag),
    .pair_zero(pair_zero)
  );

  assign mute_req = is_high || (is_float && auto_flag);

  zmute_gain_ramp #(.GAIN_W(GAIN_W), .GAIN_STEP(GAIN_STEP)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .mute_req (mute_req),
    .gain     (gain_out),
    .muted    (mute_full)
  );

  assign auto_mute = auto_flag;
endmodule

// File: rtl/zmute_ctrl_chk.sv
module zmute_ctrl_chk #(
  parameter int GAIN_W  = 8,
  parameter int RUN_LEN = 64,
  parameter int CNT_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              is_float,
  input logic              is_high,
  input logic              pair_zero,
  input logic [CNT_W-1:0]  run_cnt,
  input logic              auto_flag,
  input logic [GAIN_W-1:0] gain_out,
  input logic              pin_level
);
  assert_run_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(RUN_LEN));

  assert_low_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_float) |=> !auto_flag);

  assert_nonzero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !pair_zero) |=> !auto_flag);

  assert_rise_on_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_flag) |-> $past(smp_valid && pair_zero && is_float));

  assert_hold_without_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid) |=> $stable(gain_out));

  assert_force_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && is_high) |=> gain_out <= $past(gain_out));

  assert_high_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_high |-> pin_level);
endmodule

bind zmute_ctrl zmute_ctrl_chk #(.GAIN_W(GAIN_W), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .is_float (is_float),
  .is_high  (is_high),
  .pair_zero(pair_zero),
  .run_cnt  (run_cnt),
  .auto_flag(auto_flag),
  .gain_out (gain_out),
  .pin_level(pin_level)
);

// File: tb/sim_zmute_ctrl.sv
`timescale 1ns/1ps
module sim_zmute_ctrl;
  localparam int SMP_W = 24, GAIN_W = 8, STEP = 32, RUN = 64;
  localparam int GMAX = (1 << GAIN_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [SMP_W-1:0]  smp_left = '0, smp_right = '0;
  logic [1:0]        mute_pin = 2'b10;
  logic [GAIN_W-1:0] gain_out;
  logic              mute_full, auto_mute, pin_level;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_gain = GMAX;
  bit done = 0;

  always #2.5 clk = ~clk;

  zmute_ctrl #(.SMP_W(SMP_W), .GAIN_W(GAIN_W), .GAIN_STEP(STEP), .RUN_LEN(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .mute_pin(mute_pin), .gain_out(gain_out),
    .mute_full(mute_full), .auto_mute(auto_mute), .pin_level(pin_level));

  function automatic bit floats(input logic [1:0] p);
    return p[1];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    bit flag = (m_cnt == RUN);
    chk({tag, " gain R7"}, int'(gain_out), m_gain);
    chk({tag, " auto R2"}, int'(auto_mute), int'(flag));
    chk({tag, " muted R9"}, int'(mute_full), int'(m_gain == 0));
    chk({tag, " level R8"}, int'(pin_level),
        floats(mute_pin) ? int'(flag) : int'(mute_pin == 2'b01));
  endtask

  // Drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input int l, input int r, input logic [1:0] p,
                      input string tag);
    bit flag_old;
    smp_valid = v; smp_left = SMP_W'(l); smp_right = SMP_W'(r); mute_pin = p;
    @(posedge clk);
    flag_old = (m_cnt == RUN);
    if (v) begin
      if (p == 2'b01 || (floats(p) && flag_old)) m_gain = (m_gain - STEP < 0) ? 0 : m_gain - STEP;
      else m_gain = (m_gain + STEP > GMAX) ? GMAX : m_gain + STEP;
    end
    if (!floats(p)) m_cnt = 0;
    else if (v) m_cnt = (l == 0 && r == 0) ? ((m_cnt < RUN) ? m_cnt + 1 : RUN) : 0;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("reset gain R1", int'(gain_out), GMAX);
    chk("reset auto R1", int'(auto_mute), 0);
    chk("reset muted R1", int'(mute_full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: 63 zero pairs leave auto mute off, the 64th turns it on
    for (int i = 0; i < RUN - 1; i++) step(1, 0, 0, 2'b10, "run63 R2");
    chk("before run end R2", int'(auto_mute), 0);
    step(1, 0, 0, 2'b10, "run64 R2");
    chk("at run end R2", int'(auto_mute), 1);
    // R4: keep feeding zeros well past the limit; gain falls to zero
    for (int i = 0; i < 100; i++) step(1, 0, 0, 2'b10, "sat R4");
    chk("saturated R4", int'(auto_mute), 1);
    chk("faded R9", int'(mute_full), 1);
    // R3: non-zero on left only
    step(1, 5, 0, 2'b10, "left nz R3");
    chk("left clears R3", int'(auto_mute), 0);
    for (int i = 0; i < RUN; i++) step(1, 0, 0, 2'b10, "rerun R2");
    step(1, 0, 1, 2'b10, "right nz R3");
    chk("right clears R3", int'(auto_mute), 0);
    // R5: pin low ignores zero runs
    for (int i = 0; i < RUN + 20; i++) step(1, 0, 0, 2'b00, "low R5");
    chk("low no auto R5", int'(auto_mute), 0);
    chk("low unity R5", int'(gain_out), GMAX);
    // R6 and R7: forced mute with gaps in the strobe
    for (int i = 0; i < 4; i++) begin
      step(1, 3, 3, 2'b01, "high R6");
      step(0, 3, 3, 2'b01, "gap R7");
    end
    chk("forced down R6", int'(gain_out), GMAX - 4 * STEP);
    // R10: code 11 behaves as floating
    for (int i = 0; i < RUN; i++) step(1, 0, 0, 2'b11, "code11 R10");
    chk("code11 auto R10", int'(auto_mute), 1);
    chk("code11 level R10", int'(pin_level), 1);
    // Pin low in mid-run, then floating again restarts the count (R5)
    for (int i = 0; i < 30; i++) step(1, 0, 0, 2'b10, "part R5");
    step(0, 0, 0, 2'b00, "drop R5");
    for (int i = 0; i < RUN - 1; i++) step(1, 0, 0, 2'b10, "restart R5");
    chk("restart short R5", int'(auto_mute), 0);

    // Random phase: mostly zero pairs, occasional pin changes
    for (int i = 0; i < 3000; i++) begin
      automatic logic [1:0] p = mute_pin;
      automatic int l = ($urandom % 50 == 0) ? int'($urandom % 1000) : 0;
      automatic int r = ($urandom % 50 == 0) ? int'($urandom % 1000) : 0;
      if ($urandom % 150 == 0) p = 2'($urandom);
      step(($urandom % 4) != 0, l, r, p, "random R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule